// File: doc/BRIEF.md
# DMA Error Status Capture Unit

This block sits beside a multi-channel DMA engine. It gathers the error events that the engine reports. Each event arrives as a one-cycle strobe that carries a channel number and a vector of error causes. The block keeps one sticky error flag per channel. Software reads these flags as two 32-bit words: the high word holds channels 63..32 and the low word holds channels 31..0. The block also keeps one summary word that describes the first error seen since the flags were last all clear.

Software clears flags in two ways. It can write a channel number to a byte-wide clear port. It can also write a mask to either flag word, where each one bit clears the matching flag. A per-channel enable vector selects which flagged channels drive the single error interrupt line. Detection of bus faults and of bad descriptors takes place in the engine. Arbitration between channels is outside this block.

Top module: `dma_err_capture`

## Requirements
- R1: While `rst` is high at a clock edge, `err_status`, `flags_hi`, `flags_lo` and `err_irq` all become zero.
- R2: An `err_valid` strobe for channel c sets flag c at the next clock edge. Channels 0..31 appear as bit c of `flags_lo`. Channels 32..63 appear as bit c-32 of `flags_hi`.
- R3: When the summary word is not valid, an error strobe loads it. Bit 31 is set to 1 (valid). Bits 13:8 take the channel number. Bit 15 takes cause bit 9 (group priority fault). Bit 14 takes cause bit 8 (channel priority fault). Bits 7:0 take cause bits 7:0. Cause bits 7:0 are, in order: source address, source offset setup, destination address, destination offset setup, byte-count/iteration setup, scatter/gather setup, source bus fault and destination bus fault. All other bits are zero, and a summary word that is not valid is all zero.
- R4: While the summary word is valid and at least one flag remains set after the edge, the summary word does not change. This holds even when new errors arrive.
- R5: At the edge where the updated flags are all zero, the summary word returns to zero. A later error is then captured again under R3.
- R6: A `clr_wr` pulse with `clr_val` below 64 clears that channel's flag. A value of 64 or more leaves every flag unchanged.
- R7: `flag_wr_lo` or `flag_wr_hi` clears each flag of the low or high word whose bit in `flag_wdata` is 1. Flags at zero bits are untouched. Writing all ones clears the whole word.
- R8: When a flag is set and cleared at the same edge, the flag ends up set.
- R9: `err_irq` is registered. It equals the OR over all channels of the updated flag ANDed with that channel's `int_en` bit, so an enable change shows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Error event strobe |
| err_chan | input | 6 | Channel that reported the event |
| err_cause | input | 10 | Cause vector, bit meanings as in R3 |
| int_en | input | 64 | Per-channel error interrupt enables |
| clr_wr | input | 1 | Byte clear strobe |
| clr_val | input | 8 | Channel number to clear |
| flag_wr_lo | input | 1 | Write-one-to-clear strobe for channels 31..0 |
| flag_wr_hi | input | 1 | Write-one-to-clear strobe for channels 63..32 |
| flag_wdata | input | 32 | Clear mask for the word selected |
| err_status | output | 32 | Summary word |
| flags_hi | output | 32 | Sticky flags of channels 63..32 |
| flags_lo | output | 32 | Sticky flags of channels 31..0 |
| err_irq | output | 1 | Error interrupt |

## Verification
Every output is a register, so each result is due one clock edge after the inputs that cause it: flags, summary word and interrupt all change at the same edge. The bench drives inputs on the falling edge. It advances a reference model by exactly one step for that cycle, waits for the rising edge, and compares all three results at the following falling edge. Directed steps cover the cases that interact at one edge: set together with clear, an out-of-range byte clear, partial word masks, and a new error arriving as the last flag is cleared. A long seeded random run follows the directed steps.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  localparam int CH_W      = 6;
  localparam int CAUSE_W   = 10;
  localparam int STAT_W    = 32;
  localparam int VALID_BIT = 31;
  localparam int GPRI_BIT  = 15;
  localparam int CPRI_BIT  = 14;
  localparam int CHAN_LSB  = 8;

  function automatic logic [STAT_W-1:0] pack_status(input logic [CH_W-1:0] chan,
                                                    input logic [CAUSE_W-1:0] cause);
    logic [STAT_W-1:0] s;
    s = '0;
    s[VALID_BIT] = 1'b1;
    s[GPRI_BIT]  = cause[9];
    s[CPRI_BIT]  = cause[8];
    s[CHAN_LSB +: CH_W] = chan;
    s[7:0] = cause[7:0];
    return s;
  endfunction
endpackage

// File: rtl/dma_err_flag_bank.sv
module dma_err_flag_bank #(
  parameter int CH_W   = 6,
  parameter int NUM_CH = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [CH_W-1:0]   set_idx,
  input  logic              clr_byte_en,
  input  logic [7:0]        clr_byte,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic [NUM_CH-1:0] flags_q,
  output logic [NUM_CH-1:0] flags_next,
  output logic              flags_next_any
);
  logic [NUM_CH-1:0] set_vec;
  logic [NUM_CH-1:0] clr_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic word_clr;
    if (c < WORD_W) begin : g_lo
      assign word_clr = wr_lo && wdata[c];
    end else begin : g_hi
      assign word_clr = wr_hi && wdata[c-WORD_W];
    end
    assign set_vec[c]    = set_en && (set_idx == CH_W'(c));
    assign clr_vec[c]    = word_clr || (clr_byte_en && (clr_byte == 8'(c)));
    // set has priority over any clear in the same cycle
    assign flags_next[c] = (flags_q[c] & ~clr_vec[c]) | set_vec[c];
  end

  assign flags_next_any = |flags_next;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_next;
  end

  // R2 and R8: an error strobe always leaves its flag set
  a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
    set_en |=> flags_q[$past(set_idx)]);

  // R6: byte clear removes the flag unless the same channel is set
  a_r6_byte_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_byte_en && (clr_byte < 8'(NUM_CH)) && !set_en)
      |=> !flags_q[$past(clr_byte[CH_W-1:0])]);

  // R7: all-ones write empties the low word
  a_r7_word_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && (wdata == '1) && !set_en) |=> (flags_q[WORD_W-1:0] == '0));
endmodule

// File: rtl/dma_err_summary.sv
module dma_err_summary
  import dma_err_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               evt,
  input  logic [CH_W-1:0]    evt_chan,
  input  logic [CAUSE_W-1:0] evt_cause,
  input  logic               flags_next_any,
  output logic [STAT_W-1:0]  status_q
);
  always_ff @(posedge clk) begin
    if (rst)
      status_q <= '0;
    else if (evt && !status_q[VALID_BIT])
      status_q <= pack_status(evt_chan, evt_cause);
    else if (!flags_next_any)
      status_q <= '0;
  end

  // R4: first error is held while any flag survives
  a_r4_hold_first: assert property (@(posedge clk) disable iff (rst)
    (status_q[VALID_BIT] && flags_next_any) |=> $stable(status_q));

  // R5: summary released once no flag survives
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    !flags_next_any |=> (status_q == '0));

  // R3: a summary word without the valid flag carries nothing
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !status_q[VALID_BIT] |-> (status_q == '0));
endmodule

// File: rtl/dma_err_irq.sv
module dma_err_irq #(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] flags_next,
  input  logic [NUM_CH-1:0] flags_now,
  input  logic [NUM_CH-1:0] en,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_next & en);
  end

  // R9: interrupt never stands without a flagged channel
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flags_now != '0));
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dma_err_pkg::*;
#(
  parameter int NUM_CH = 2**CH_W,
  parameter int WORD_W = NUM_CH/2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               err_valid,
  input  logic [CH_W-1:0]    err_chan,
  input  logic [CAUSE_W-1:0] err_cause,
  input  logic [NUM_CH-1:0]  int_en,
  input  logic               clr_wr,
  input  logic [7:0]         clr_val,
  input  logic               flag_wr_lo,
  input  logic               flag_wr_hi,
  input  logic [WORD_W-1:0]  flag_wdata,
  output logic [STAT_W-1:0]  err_status,
  output logic [WORD_W-1:0]  flags_hi,
  output logic [WORD_W-1:0]  flags_lo,
  output logic               err_irq
);
  logic [NUM_CH-1:0] flags_q;
  logic [NUM_CH-1:0] flags_next;
  logic              flags_next_any;

  dma_err_flag_bank #(.CH_W(CH_W), .NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_flags (
    .clk            (clk),
    .rst            (rst),
    .set_en         (err_valid),
    .set_idx        (err_chan),
    .clr_byte_en    (clr_wr),
    .clr_byte       (clr_val),
    .wr_lo          (flag_wr_lo),
    .wr_hi          (flag_wr_hi),
    .wdata          (flag_wdata),
    .flags_q        (flags_q),
    .flags_next     (flags_next),
    .flags_next_any (flags_next_any)
  );

  dma_err_summary u_summary (
    .clk            (clk),
    .rst            (rst),
    .evt            (err_valid),
    .evt_chan       (err_chan),
    .evt_cause      (err_cause),
    .flags_next_any (flags_next_any),
    .status_q       (err_status)
  );

  dma_err_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .flags_next (flags_next),
    .flags_now  (flags_q),
    .en         (int_en),
    .irq_q      (err_irq)
  );

  assign flags_lo = flags_q[WORD_W-1:0];
  assign flags_hi = flags_q[NUM_CH-1:WORD_W];

  // R3: a fresh capture records the reporting channel
  a_r3_chan_field: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !err_status[VALID_BIT])
      |=> (err_status[CHAN_LSB +: CH_W] == $past(err_chan)));
endmodule

// File: tb/test_dma_err_capture.sv
`timescale 1ns/1ps
module test_dma_err_capture;
  logic        clk = 1'b0;
  logic        rst;
  logic        err_valid;
  logic [5:0]  err_chan;
  logic [9:0]  err_cause;
  logic [63:0] int_en;
  logic        clr_wr;
  logic [7:0]  clr_val;
  logic        flag_wr_lo;
  logic        flag_wr_hi;
  logic [31:0] flag_wdata;
  logic [31:0] err_status;
  logic [31:0] flags_hi;
  logic [31:0] flags_lo;
  logic        err_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] m_flags;
  logic [31:0] m_status;
  logic        m_irq;

  always #2 clk = ~clk;

  dma_err_capture i_dma_err_capture (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_chan(err_chan),
    .err_cause(err_cause), .int_en(int_en), .clr_wr(clr_wr), .clr_val(clr_val),
    .flag_wr_lo(flag_wr_lo), .flag_wr_hi(flag_wr_hi), .flag_wdata(flag_wdata),
    .err_status(err_status), .flags_hi(flags_hi), .flags_lo(flags_lo),
    .err_irq(err_irq)
  );

  function automatic logic [31:0] exp_word(input logic [5:0] ch, input logic [9:0] ca);
    return {1'b1, 15'd0, ca[9], ca[8], ch, ca[7:0]};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    err_valid = 0; err_chan = 0; err_cause = 0;
    clr_wr = 0; clr_val = 0; flag_wr_lo = 0; flag_wr_hi = 0; flag_wdata = 0;
  endtask

  // inputs already set on the falling edge; advance model one edge and compare
  task automatic step(input string tag);
    logic [63:0] clr, fn;
    clr = '0;
    if (clr_wr && clr_val < 8'd64) clr[clr_val[5:0]] = 1'b1;
    if (flag_wr_lo) clr[31:0]  = clr[31:0]  | flag_wdata;
    if (flag_wr_hi) clr[63:32] = clr[63:32] | flag_wdata;
    fn = m_flags & ~clr;
    if (err_valid) fn[err_chan] = 1'b1;
    if (err_valid && !m_status[31]) m_status = exp_word(err_chan, err_cause);
    else if (fn == '0)              m_status = '0;
    m_irq   = |(fn & int_en);
    m_flags = fn;
    @(posedge clk);
    @(negedge clk);
    check(tag, "status", 64'(err_status), 64'(m_status));
    check(tag, "flags", {flags_hi, flags_lo}, m_flags);
    check(tag, "irq", 64'(err_irq), 64'(m_irq));
    idle_inputs();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    int_en = '0;
    rst = 1;
    err_valid = 1; err_chan = 6'd3; err_cause = 10'h3FF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state despite active stimulus
    check("R1", "status", 64'(err_status), 64'd0);
    check("R1", "flags", {flags_hi, flags_lo}, 64'd0);
    check("R1", "irq", 64'(err_irq), 64'd0);
    rst = 0;
    idle_inputs();
    m_flags = '0; m_status = '0; m_irq = 0;

    // R2 R3: first error, full cause vector
    err_valid = 1; err_chan = 6'd5; err_cause = 10'h3FF;
    step("R3");
    check("R3", "word", 64'(err_status), 64'h8000C5FF);
    // R2 R4: high-word channel, summary held
    err_valid = 1; err_chan = 6'd40; err_cause = 10'h001;
    step("R4");
    check("R2", "hi bit", 64'(flags_hi[8]), 64'd1);
    // R9: enable reaches irq one edge later
    int_en = 64'd1 << 40;
    step("R9");
    check("R9", "irq on", 64'(err_irq), 64'd1);
    // R6: out-of-range byte clear has no effect
    clr_wr = 1; clr_val = 8'd70;
    step("R6");
    clr_wr = 1; clr_val = 8'd64;
    step("R6");
    // R6 R9: clear channel 40, irq drops
    clr_wr = 1; clr_val = 8'd40;
    step("R6");
    check("R9", "irq off", 64'(err_irq), 64'd0);
    // R8: set and clear of channel 7 together
    err_valid = 1; err_chan = 6'd7; err_cause = 10'h010;
    clr_wr = 1; clr_val = 8'd7;
    step("R8");
    check("R8", "flag7", 64'(flags_lo[7]), 64'd1);
    // R7: partial mask leaves zero-bit flags
    flag_wr_lo = 1; flag_wdata = 32'h0000_0020;
    step("R7");
    check("R7", "flag7 kept", 64'(flags_lo[7]), 64'd1);
    // R7 R5: all-ones clears the word and releases the summary
    flag_wr_lo = 1; flag_wdata = 32'hFFFF_FFFF;
    step("R5");
    check("R5", "released", 64'(err_status), 64'd0);
    // R5: recapture
    err_valid = 1; err_chan = 6'd33; err_cause = 10'h200;
    step("R5");
    check("R5", "recapture", 64'(err_status), 64'h8000A100);
    // R5: new error while last flag is cleared keeps summary valid
    err_valid = 1; err_chan = 6'd2; err_cause = 10'h004;
    flag_wr_hi = 1; flag_wdata = 32'h0000_0002;
    step("R5");
    flag_wr_lo = 1; flag_wdata = 32'hFFFF_FFFF;
    step("R5");

    // random mix covering R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(99) < 5) int_en = {$urandom(), $urandom()};
      err_valid = ($urandom_range(99) < 30);
      err_chan  = 6'($urandom());
      err_cause = 10'($urandom());
      clr_wr    = ($urandom_range(99) < 25);
      clr_val   = 8'($urandom_range(79));
      if ($urandom_range(99) < 8) begin
        flag_wr_lo = 1; flag_wr_hi = 1;
        flag_wdata = ($urandom_range(1) == 1) ? 32'hFFFF_FFFF : $urandom();
      end else if ($urandom_range(99) < 10) begin
        flag_wr_lo = $urandom_range(1); flag_wr_hi = $urandom_range(1);
        flag_wdata = $urandom();
      end
      step("RND R2 R3 R4 R5 R6 R7 R8 R9");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule